// File: doc/BRIEF.md
# Accumulator Processor Core with Built-in Program

This block is a small 8-bit processor that runs a fixed program stored as a constant table inside it. It has three parts. A two-state controller fetches and decodes instructions. A program-counter path steps through a 32-word instruction table. An accumulator path holds the working value and computes on it, using a 32-byte data memory as its second operand.

The controller does not pass the instruction opcode straight to the accumulator path. It translates each opcode into an internal micro-operation. The immediate-load instruction reuses the 5-bit operand field as a data value. The block has no inputs besides clock and reset. The program counter and the accumulator are brought out as observation ports, so a testbench can follow execution one instruction at a time.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the core clears the program counter and the accumulator to zero and returns to the fetch state. This holds even when reset arrives in the middle of an instruction.
- R2: Every instruction takes exactly two clock edges, a fetch edge and then an execute edge. The fetch edge changes neither `dbg_pc` nor `dbg_acc`. The results of the instruction appear after the execute edge.
- R3: An instruction word is 8 bits. Bits [7:5] hold the opcode and bits [4:0] hold the operand field. The opcodes are: 0 load, 1 store, 2 load-immediate, 3 add, 4 and, 5 not, 6 jump, 7 jump-if-zero.
- R4: Store writes the accumulator to data memory at the operand field and leaves the accumulator unchanged. Load copies the data memory byte at the operand field into the accumulator.
- R5: Load-immediate sets the accumulator to the operand field, zero-extended to 8 bits.
- R6: The arithmetic and logic instructions all take their second operand from data memory at the operand field. Add sets the accumulator to the sum of the accumulator and that byte, modulo 256. And sets it to their bitwise AND. Not sets it to the bitwise inverse of that byte.
- R7: Every instruction that is not a jump advances the program counter by one. The counter wraps from 31 to 0.
- R8: Jump loads the program counter with the operand field and leaves the accumulator unchanged.
- R9: Jump-if-zero loads the program counter with the operand field when the accumulator is zero. Otherwise it advances the counter by one. The accumulator is unchanged in both cases.
- R10: The built-in program, given as address: instruction, is:
  - 0: ldi 5
  - 1: st 3
  - 2: ldi 9
  - 3: add 3
  - 4: st 4
  - 5: not 4
  - 6: and 3
  - 7: jz 20
  - 8: ldi 0
  - 9: jz 12
  - 10: ldi 31
  - 11: ldi 30
  - 12: ld 4
  - 13: add 4
  - 14: add 4
  - 15: st 5
  - 16 to 21: add 5
  - 22: jmp 24
  - 23: ldi 7
  - 24: ldi 31
  - 25: st 6
  - 26: ld 6
  - 27: not 5
  - 28: and 6
  - 29: jmp 31
  - 30: ldi 1
  - 31: ldi 3

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 5 | Current program counter |
| dbg_acc | output | 8 | Current accumulator value |

## Verification
The hardest case to reach is a reset that arrives between the fetch and execute edges of one instruction. A controller that does not return to fetch would then run one cycle out of phase from that point on. The bench waits until a fetch edge has passed and then raises reset. After reset it checks that every later instruction still completes on the second edge.

The program itself supplies the other corner cases. It takes jump-if-zero both ways, wraps the sum past 255, wraps the counter from 31 to 0 without a jump, and loops over its own stored data more than once.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [2:0] {
      OP_LD  = 3'd0,
      OP_ST  = 3'd1,
      OP_LDI = 3'd2,
      OP_ADD = 3'd3,
      OP_AND = 3'd4,
      OP_NOT = 3'd5,
      OP_JMP = 3'd6,
      OP_JZ  = 3'd7
   } opcode_e;

   // micro-operation handed from the controller to the accumulator path
   typedef enum logic [2:0] {
      UOP_KEEP = 3'd0,
      UOP_MEM  = 3'd1,
      UOP_IMM  = 3'd2,
      UOP_SUM  = 3'd3,
      UOP_MASK = 3'd4,
      UOP_INV  = 3'd5
   } uop_e;

   typedef enum logic {
      ST_FETCH = 1'b0,
      ST_EXEC  = 1'b1
   } phase_e;

   function automatic logic [7:0] enc(opcode_e op, int unsigned fld);
      return {op, fld[4:0]};
   endfunction

   // built-in program (R10)
   function automatic logic [7:0] prog_word(int unsigned idx);
      logic [7:0] w;
      case (idx)
         0:  w = enc(OP_LDI, 5);
         1:  w = enc(OP_ST, 3);
         2:  w = enc(OP_LDI, 9);
         3:  w = enc(OP_ADD, 3);
         4:  w = enc(OP_ST, 4);
         5:  w = enc(OP_NOT, 4);
         6:  w = enc(OP_AND, 3);
         7:  w = enc(OP_JZ, 20);
         8:  w = enc(OP_LDI, 0);
         9:  w = enc(OP_JZ, 12);
         10: w = enc(OP_LDI, 31);
         11: w = enc(OP_LDI, 30);
         12: w = enc(OP_LD, 4);
         13: w = enc(OP_ADD, 4);
         14: w = enc(OP_ADD, 4);
         15: w = enc(OP_ST, 5);
         16, 17, 18, 19, 20, 21: w = enc(OP_ADD, 5);
         22: w = enc(OP_JMP, 24);
         23: w = enc(OP_LDI, 7);
         24: w = enc(OP_LDI, 31);
         25: w = enc(OP_ST, 6);
         26: w = enc(OP_LD, 6);
         27: w = enc(OP_NOT, 5);
         28: w = enc(OP_AND, 6);
         29: w = enc(OP_JMP, 31);
         30: w = enc(OP_LDI, 1);
         31: w = enc(OP_LDI, 3);
         default: w = enc(OP_JMP, 0);
      endcase
      return w;
   endfunction

endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[addr] <= wdata;
   end

   assign rdata = mem_q[addr];

   AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
      we |=> (addr != $past(addr)) || (rdata == $past(wdata))); // R4

endmodule

// File: rtl/acc_cpu_pcpath.sv
module acc_cpu_pcpath #(
   parameter int ADDR_W  = 5,
   parameter int INSTR_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               pc_inc,
   input  logic               pc_load,
   input  logic [ADDR_W-1:0]  target,
   output logic [ADDR_W-1:0]  pc,
   output logic [INSTR_W-1:0] instr
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [INSTR_W-1:0] rom [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
      assign rom[gi] = INSTR_W'(acc_cpu_pkg::prog_word(gi));
   end

   always_ff @(posedge clk) begin
      if (rst)          pc <= '0;
      else if (pc_load) pc <= target;
      else if (pc_inc)  pc <= pc + ADDR_W'(1);
   end

   assign instr = rom[pc];

   AST_PC_RESET: assert property (@(posedge clk)
      rst |=> pc == '0); // R1
   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (pc_inc && !pc_load) |=> pc == $past(pc) + ADDR_W'(1)); // R7
   AST_PC_JUMP: assert property (@(posedge clk) disable iff (rst)
      pc_load |=> pc == $past(target)); // R8
   AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!pc_inc && !pc_load) |=> $stable(pc)); // R2

endmodule

// File: rtl/acc_cpu_accpath.sv
module acc_cpu_accpath
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  uop_e              uop,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] imm,
   input  logic [DATA_W-1:0] mem_rd,
   output logic [DATA_W-1:0] acc,
   output logic              acc_zero
);
   localparam int PAD_W = DATA_W - ADDR_W;

   logic [DATA_W-1:0] acc_d;

   always_comb begin
      case (uop)
         UOP_MEM:  acc_d = mem_rd;
         UOP_IMM:  acc_d = {{PAD_W{1'b0}}, imm};
         UOP_SUM:  acc_d = acc + mem_rd;
         UOP_MASK: acc_d = acc & mem_rd;
         UOP_INV:  acc_d = ~mem_rd;
         default:  acc_d = acc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)         acc <= '0;
      else if (acc_we) acc <= acc_d;
   end

   assign acc_zero = (acc == '0);

   AST_ACC_RESET: assert property (@(posedge clk)
      rst |=> acc == '0); // R1
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !acc_we |=> $stable(acc)); // R9
   AST_ACC_IMM: assert property (@(posedge clk) disable iff (rst)
      (acc_we && uop == UOP_IMM) |=> acc == {{PAD_W{1'b0}}, $past(imm)}); // R5
   AST_ACC_INV: assert property (@(posedge clk) disable iff (rst)
      (acc_we && uop == UOP_INV) |=> (acc ^ $past(mem_rd)) == '1); // R6

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int OPC_W  = 3,
   parameter int ADDR_W = 5
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [OPC_W+ADDR_W-1:0] instr,
   input  logic                    acc_zero,
   output logic                    in_exec,
   output opcode_e                 cur_op,
   output logic [ADDR_W-1:0]       field,
   output uop_e                    uop,
   output logic                    acc_we,
   output logic                    ram_we,
   output logic                    pc_inc,
   output logic                    pc_load
);
   localparam int INSTR_W = OPC_W + ADDR_W;

   phase_e             phase_q;
   logic [INSTR_W-1:0] ir_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= ST_FETCH;
         ir_q    <= '0;
      end else if (phase_q == ST_FETCH) begin
         ir_q    <= instr;
         phase_q <= ST_EXEC;
      end else begin
         phase_q <= ST_FETCH;
      end
   end

   assign in_exec = (phase_q == ST_EXEC);
   assign cur_op  = opcode_e'(ir_q[INSTR_W-1 -: OPC_W]);
   assign field   = ir_q[ADDR_W-1:0];

   always_comb begin
      uop     = UOP_KEEP;
      acc_we  = 1'b0;
      ram_we  = 1'b0;
      pc_inc  = 1'b0;
      pc_load = 1'b0;
      if (in_exec) begin
         pc_inc = 1'b1;
         case (cur_op)
            OP_LD:  begin uop = UOP_MEM;  acc_we = 1'b1; end
            OP_ST:  ram_we = 1'b1;
            OP_LDI: begin uop = UOP_IMM;  acc_we = 1'b1; end
            OP_ADD: begin uop = UOP_SUM;  acc_we = 1'b1; end
            OP_AND: begin uop = UOP_MASK; acc_we = 1'b1; end
            OP_NOT: begin uop = UOP_INV;  acc_we = 1'b1; end
            OP_JMP: begin pc_inc = 1'b0; pc_load = 1'b1; end
            OP_JZ:  begin pc_inc = !acc_zero; pc_load = acc_zero; end
            default: ;
         endcase
      end
   end

   AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
      !in_exec |=> in_exec); // R2
   AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (rst)
      !in_exec |-> !(acc_we || ram_we || pc_inc || pc_load)); // R2
   AST_ONE_PC_ACTION: assert property (@(posedge clk) disable iff (rst)
      in_exec |-> $onehot({pc_inc, pc_load})); // R7

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5,
   parameter int OPC_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] dbg_pc,
   output logic [DATA_W-1:0] dbg_acc
);
   localparam int INSTR_W = OPC_W + ADDR_W;

   if (DATA_W <= ADDR_W) begin : g_bad_data_w
      $error("acc_cpu: DATA_W must exceed ADDR_W");
   end
   if (OPC_W != 3) begin : g_bad_opc_w
      $error("acc_cpu: eight instructions need OPC_W of 3");
   end
   if (INSTR_W != 8) begin : g_bad_instr_w
      $error("acc_cpu: built-in program uses 8-bit words");
   end

   logic [INSTR_W-1:0] instr;
   logic [ADDR_W-1:0]  field;
   logic [DATA_W-1:0]  mem_rd;
   logic               in_exec, acc_zero, acc_we, ram_we, pc_inc, pc_load;
   opcode_e            cur_op;
   uop_e               uop;

   acc_cpu_ctrl #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst(rst), .instr(instr), .acc_zero(acc_zero),
      .in_exec(in_exec), .cur_op(cur_op), .field(field), .uop(uop),
      .acc_we(acc_we), .ram_we(ram_we), .pc_inc(pc_inc), .pc_load(pc_load)
   );

   acc_cpu_pcpath #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_pc (
      .clk(clk), .rst(rst), .pc_inc(pc_inc), .pc_load(pc_load),
      .target(field), .pc(dbg_pc), .instr(instr)
   );

   acc_cpu_accpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_acc (
      .clk(clk), .rst(rst), .uop(uop), .acc_we(acc_we), .imm(field),
      .mem_rd(mem_rd), .acc(dbg_acc), .acc_zero(acc_zero)
   );

   acc_cpu_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .rst(rst), .we(ram_we), .addr(field),
      .wdata(dbg_acc), .rdata(mem_rd)
   );

   AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (in_exec && cur_op == OP_JZ && dbg_acc == '0) |=> dbg_pc == $past(field)); // R9
   AST_JUMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
      (in_exec && (cur_op == OP_JMP || cur_op == OP_JZ || cur_op == OP_ST))
      |=> $stable(dbg_acc)); // R8

endmodule

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] dbg_pc;
   logic [7:0] dbg_acc;

   int n_chk  = 0;
   int n_fail = 0;

   typedef struct {
      logic [4:0] pc;
      logic [7:0] acc;
      string      req;
   } exp_t;

   exp_t exp_q[$];

   // reference model state
   int unsigned mpc  = 0;
   logic [7:0]  macc = 8'd0;
   logic [7:0]  mmem [32];
   logic [4:0]  prev_pc  = 5'd0;
   logic [7:0]  prev_acc = 8'd0;

   acc_cpu dut (.clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_acc(dbg_acc));

   always #5 clk = ~clk;

   // program listing from R10, encoding from R3
   function automatic logic [7:0] w(int op, int f);
      logic [2:0] o = 3'(op);
      logic [4:0] a = 5'(f);
      return {o, a};
   endfunction

   function automatic logic [7:0] listing(int unsigned a);
      case (a)
         0: return w(2, 5);   1: return w(1, 3);   2: return w(2, 9);
         3: return w(3, 3);   4: return w(1, 4);   5: return w(5, 4);
         6: return w(4, 3);   7: return w(7, 20);  8: return w(2, 0);
         9: return w(7, 12);  10: return w(2, 31); 11: return w(2, 30);
         12: return w(0, 4);  13: return w(3, 4);  14: return w(3, 4);
         15: return w(1, 5);  22: return w(6, 24); 23: return w(2, 7);
         24: return w(2, 31); 25: return w(1, 6);  26: return w(0, 6);
         27: return w(5, 5);  28: return w(4, 6);  29: return w(6, 31);
         30: return w(2, 1);  31: return w(2, 3);
         default: return w(3, 5); // 16..21
      endcase
   endfunction

   // driver: run the model and push expected state after each instruction
   task automatic predict(int n);
      for (int i = 0; i < n; i++) begin
         logic [7:0] ins = listing(mpc);
         int         op  = int'(ins[7:5]);
         logic [4:0] f   = ins[4:0];
         string      tag;
         int unsigned npc = (mpc + 1) % 32;
         case (op)
            0: begin macc = mmem[f]; tag = "R4 load"; end
            1: begin mmem[f] = macc; tag = "R4 store"; end
            2: begin macc = {3'b000, f}; tag = "R5 ldi"; end
            3: begin macc = macc + mmem[f]; tag = "R6 add"; end
            4: begin macc = macc & mmem[f]; tag = "R6 and"; end
            5: begin macc = ~mmem[f]; tag = "R6 not"; end
            6: begin npc = f; tag = "R8 jmp"; end
            default: begin
               if (macc == 8'd0) npc = f;
               tag = "R9 jz";
            end
         endcase
         if (mpc == 31 && op < 6) tag = {tag, " R7 wrap"};
         mpc = npc;
         exp_q.push_back('{pc: 5'(npc), acc: macc, req: {tag, " R3 R10"}});
      end
   endtask

   task automatic check(string req, logic [4:0] apc, logic [7:0] aacc,
                        logic [4:0] epc, logic [7:0] eacc);
      n_chk++;
      if (apc !== epc || aacc !== eacc) begin
         n_fail++;
         $display("FAIL %s: pc/acc actual %0d/%0d expected %0d/%0d",
                  req, apc, aacc, epc, eacc);
      end
   endtask

   // monitor: pop expected items as instructions complete
   task automatic monitor(int n);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         @(posedge clk);
         @(negedge clk);
         check("R2 fetch edge", dbg_pc, dbg_acc, prev_pc, prev_acc);
         @(posedge clk);
         @(negedge clk);
         e = exp_q.pop_front();
         check(e.req, dbg_pc, dbg_acc, e.pc, e.acc);
         prev_pc  = e.pc;
         prev_acc = e.acc;
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mmem[i] = 8'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset", dbg_pc, dbg_acc, 5'd0, 8'd0);
      predict(40);
      rst = 1'b0;
      monitor(40);
      // reset between the fetch and execute edges of an instruction
      @(posedge clk);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 mid-instruction reset", dbg_pc, dbg_acc, 5'd0, 8'd0);
      mpc      = 0;
      macc     = 8'd0;
      prev_pc  = 5'd0;
      prev_acc = 8'd0;
      exp_q.delete();
      predict(34);
      rst = 1'b0;
      monitor(34);
      finish_run();
   end

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

endmodule